// File: doc/BRIEF.md
# TDM Timeslot Serial Channel Port

This block is one direction-pair of a time-division-multiplexed serial voice port. A single bit clock carries a frame made of fixed-width timeslots. A short frame-sync pulse restarts an internal position counter. The port then finds two independently programmed slots. In the receive slot it shifts in one word from the serial input. In the transmit slot it shifts one word out on a serial line. That line is driven only for the length of the word, so other devices can share the wire.

The word width follows the side's role. An expanding side takes in 4-bit compressed words and sends 8-bit linear-code words. A compressing side takes in 8-bit words and sends 4-bit words. A loop mode returns each received 8-bit word unchanged in the transmit slot. An idle mode and a separate disable input keep the line undriven. Received words appear on a parallel bus with a one-cycle strobe. Transmit words are taken from a parallel input at the start of the slot. The compression and companding arithmetic lies outside this block.

Top module: `tdm_slot_port`

## Requirements
- R1: After reset, serOutEn, serOut, rxValid and rxData are all 0. Until the first frame sync is sampled, the port captures nothing and never drives the line.
- R2: A falling bit-clock edge that samples frameSync high defines the next falling edge as position 0. Timeslot n spans positions 8n to 8n+7. Bit k of a word lies at position 8n+k, and a slot-0 word starts directly after the sync.
- R3: Serial input is sampled on falling edges, most significant bit first, in slot inSlot. The width is 4 bits when expandSide=1 and 8 bits when expandSide=0. A 4-bit word appears in rxData[3:0] with rxData[7:4]=0. rxData changes only when rxValid rises.
- R4: rxValid is high for exactly one bit-clock period, starting at the falling edge that samples the last bit of the word. This happens once per received word.
- R5: serOutEn rises at the rising edge that comes before the falling edge of the first bit of slot outSlot. It stays high for exactly the word width: 8 bits when expandSide=1, 4 bits when expandSide=0. serOut is 0 whenever serOutEn is 0.
- R6: Transmitted bits go out most significant bit first, from a copy of txData taken at the slot's first bit. An 8-bit word uses txData[7:0] and a 4-bit word uses txData[3:0]. Changing txData later in the slot has no effect.
- R7: modeSel=2'b01 (loop) sets both widths to 8 bits. The output slot carries the last received word, as held in rxData at the slot's first bit.
- R8: modeSel=2'b10 or 2'b11 (idle) keeps serOutEn at 0, while reception continues as in R3.
- R9: portDisable=1 keeps serOutEn at 0 on every cycle, while reception continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Serial bit clock; inputs are sampled on its falling edge |
| rstN | input | 1 | Asynchronous active-low reset |
| frameSync | input | 1 | Frame start pulse, at most one bit period wide |
| serIn | input | 1 | Serial receive data |
| inSlot | input | 5 | Receive timeslot number |
| outSlot | input | 5 | Transmit timeslot number |
| expandSide | input | 1 | 1: receive 4-bit, send 8-bit; 0: the reverse |
| modeSel | input | 2 | 00 normal, 01 loop, 1x idle |
| portDisable | input | 1 | Forces the line undriven |
| txData | input | 8 | Parallel word to transmit |
| serOut | output | 1 | Serial transmit data |
| serOutEn | output | 1 | Line drive enable; 0 means high impedance |
| rxData | output | 8 | Last received word |
| rxValid | output | 1 | One-period strobe for a new rxData word |

## Verification
The bound checker watches the line-quiet rules on every cycle. It checks that disable and idle force the drive enable off on the following edge, that a drive run never exceeds one 8-bit word, that the data line is low while undriven, and that the receive strobe is a single period with rxData moving only alongside it. Only the bench's frames can show where each word falls in the frame. This covers slot-0 and last-slot placement, the bit order, the width set by role and mode, the snapshot of txData, and the loop mode returning the right word whether the receive slot comes before or after the transmit slot.

// File: rtl/tdm_slot_pkg.sv
`timescale 1ns/1ps
package tdm_slot_pkg;
  localparam int PCM_W   = 8;
  localparam int ADPCM_W = 4;
  localparam int IDX_W   = $clog2(PCM_W);

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_LOOP   = 2'b01,
    MODE_IDLE   = 2'b10,
    MODE_IDLE2  = 2'b11
  } tdm_mode_e;

  typedef struct packed {
    logic             inActive;
    logic             inLast;
    logic             inWide;
    logic             outActive;
    logic             outFirst;
    logic             outWide;
    logic             loopBack;
    logic [IDX_W-1:0] bitIdx;
  } slot_strobe_t;
endpackage

// File: rtl/tdm_slot_ctrl.sv
`timescale 1ns/1ps
module tdm_slot_ctrl
  import tdm_slot_pkg::*;
#(
  parameter int SLOTS      = 32,
  parameter int SLOT_BITS  = 8,
  localparam int SLOT_IDX_W = $clog2(SLOTS)
) (
  input  logic                  bitClk,
  input  logic                  rstN,
  input  logic                  frameSync,
  input  logic [SLOT_IDX_W-1:0] inSlot,
  input  logic [SLOT_IDX_W-1:0] outSlot,
  input  logic                  expandSide,
  input  tdm_mode_e             mode,
  input  logic                  portDisable,
  output slot_strobe_t          strb
);
  localparam int FRAME_BITS = SLOTS * SLOT_BITS;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam int BIT_W      = $clog2(SLOT_BITS);
  localparam int LEN_W      = BIT_W + 1;

  logic [CNT_W-1:0]      posCnt;
  logic                  frameValid;
  logic [SLOT_IDX_W-1:0] slotNow;
  logic [BIT_W-1:0]      bitNow;
  logic [LEN_W-1:0]      inLen;
  logic [LEN_W-1:0]      outLen;
  logic                  loopMode;
  logic                  idleMode;
  logic                  inWide;
  logic                  outWide;
  logic                  inHit;

  // position of the bit sampled at the coming falling edge
  always_ff @(negedge bitClk or negedge rstN) begin
    if (!rstN) begin
      posCnt     <= '0;
      frameValid <= 1'b0;
    end else if (frameSync) begin
      posCnt     <= '0;
      frameValid <= 1'b1;
    end else if (frameValid) begin
      if (posCnt == CNT_W'(FRAME_BITS - 1)) posCnt <= '0;
      else                                  posCnt <= posCnt + 1'b1;
    end
  end

  always_comb begin
    slotNow  = posCnt[CNT_W-1:BIT_W];
    bitNow   = posCnt[BIT_W-1:0];
    loopMode = (mode == MODE_LOOP);
    idleMode = (mode == MODE_IDLE) || (mode == MODE_IDLE2);
    inWide   = loopMode || !expandSide;
    outWide  = loopMode || expandSide;
    inLen    = inWide  ? LEN_W'(PCM_W) : LEN_W'(ADPCM_W);
    outLen   = outWide ? LEN_W'(PCM_W) : LEN_W'(ADPCM_W);
    inHit    = frameValid && (slotNow == inSlot) && ({1'b0, bitNow} < inLen);

    strb.inActive  = inHit;
    strb.inLast    = inHit && ({1'b0, bitNow} == inLen - 1'b1);
    strb.inWide    = inWide;
    strb.outActive = frameValid && !idleMode && !portDisable &&
                     (slotNow == outSlot) && ({1'b0, bitNow} < outLen);
    strb.outFirst  = (bitNow == '0);
    strb.outWide   = outWide;
    strb.loopBack  = loopMode;
    strb.bitIdx    = IDX_W'(bitNow);
  end
endmodule

// File: rtl/tdm_slot_dp.sv
`timescale 1ns/1ps
module tdm_slot_dp
  import tdm_slot_pkg::*;
(
  input  logic             bitClk,
  input  logic             rstN,
  input  logic             serIn,
  input  slot_strobe_t     strb,
  input  logic [PCM_W-1:0] txData,
  output logic             serOut,
  output logic             serOutEn,
  output logic [PCM_W-1:0] rxData,
  output logic             rxValid
);
  logic [PCM_W-2:0] shiftIn;
  logic [PCM_W-1:0] txSnap;
  logic [PCM_W-1:0] txSrc;

  function automatic logic pickBit(input logic [PCM_W-1:0] word,
                                   input logic             wide,
                                   input logic [IDX_W-1:0] idx);
    logic [IDX_W-1:0] msb;
    msb = wide ? IDX_W'(PCM_W - 1) : IDX_W'(ADPCM_W - 1);
    return word[msb - idx];
  endfunction

  // receive path: falling edge
  always_ff @(negedge bitClk or negedge rstN) begin
    if (!rstN) begin
      shiftIn <= '0;
      rxData  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (strb.inActive) begin
        shiftIn <= {shiftIn[PCM_W-3:0], serIn};
        if (strb.inLast) begin
          rxValid <= 1'b1;
          if (strb.inWide) rxData <= {shiftIn, serIn};
          else             rxData <= PCM_W'({shiftIn[ADPCM_W-2:0], serIn});
        end
      end
    end
  end

  assign txSrc = strb.loopBack ? rxData : txData;

  // transmit path: rising edge, ahead of the sampling falling edge
  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      serOut   <= 1'b0;
      serOutEn <= 1'b0;
      txSnap   <= '0;
    end else if (strb.outActive) begin
      serOutEn <= 1'b1;
      if (strb.outFirst) begin
        txSnap <= txSrc;
        serOut <= pickBit(txSrc, strb.outWide, '0);
      end else begin
        serOut <= pickBit(txSnap, strb.outWide, strb.bitIdx);
      end
    end else begin
      serOutEn <= 1'b0;
      serOut   <= 1'b0;
    end
  end
endmodule

// File: rtl/tdm_slot_port.sv
`timescale 1ns/1ps
module tdm_slot_port
  import tdm_slot_pkg::*;
#(
  parameter int SLOTS      = 32,
  parameter int SLOT_BITS  = 8,
  localparam int SLOT_IDX_W = $clog2(SLOTS)
) (
  input  logic                  bitClk,
  input  logic                  rstN,
  input  logic                  frameSync,
  input  logic                  serIn,
  input  logic [SLOT_IDX_W-1:0] inSlot,
  input  logic [SLOT_IDX_W-1:0] outSlot,
  input  logic                  expandSide,
  input  logic [1:0]            modeSel,
  input  logic                  portDisable,
  input  logic [7:0]            txData,
  output logic                  serOut,
  output logic                  serOutEn,
  output logic [7:0]            rxData,
  output logic                  rxValid
);
  slot_strobe_t strb;
  tdm_mode_e    mode;

  assign mode = tdm_mode_e'(modeSel);

  tdm_slot_ctrl #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_ctrl (
    .bitClk      (bitClk),
    .rstN        (rstN),
    .frameSync   (frameSync),
    .inSlot      (inSlot),
    .outSlot     (outSlot),
    .expandSide  (expandSide),
    .mode        (mode),
    .portDisable (portDisable),
    .strb        (strb)
  );

  tdm_slot_dp u_dp (
    .bitClk   (bitClk),
    .rstN     (rstN),
    .serIn    (serIn),
    .strb     (strb),
    .txData   (txData),
    .serOut   (serOut),
    .serOutEn (serOutEn),
    .rxData   (rxData),
    .rxValid  (rxValid)
  );
endmodule

// File: rtl/tdm_slot_port_chk.sv
`timescale 1ns/1ps
module tdm_slot_port_chk (
  input logic       bitClk,
  input logic       rstN,
  input logic       portDisable,
  input logic [1:0] modeSel,
  input logic       serOut,
  input logic       serOutEn,
  input logic [7:0] rxData,
  input logic       rxValid
);
  localparam int MAX_RUN = 8;
  logic [4:0] runLen;

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN)                  runLen <= '0;
    else if (!serOutEn)         runLen <= '0;
    else if (runLen != 5'd31)   runLen <= runLen + 1'b1;
  end

  p_disable_hiz_r9: assert property (@(posedge bitClk) disable iff (!rstN)
    portDisable |=> !serOutEn);

  p_idle_hiz_r8: assert property (@(posedge bitClk) disable iff (!rstN)
    modeSel[1] |=> !serOutEn);

  p_run_len_r5: assert property (@(posedge bitClk) disable iff (!rstN)
    runLen <= 5'(MAX_RUN));

  p_quiet_low_r5: assert property (@(posedge bitClk) disable iff (!rstN)
    !serOutEn |-> !serOut);

  p_valid_pulse_r4: assert property (@(negedge bitClk) disable iff (!rstN)
    rxValid |=> !rxValid);

  p_rxdata_hold_r3: assert property (@(negedge bitClk) disable iff (!rstN)
    !$stable(rxData) |-> rxValid);
endmodule

bind tdm_slot_port tdm_slot_port_chk u_chk (
  .bitClk      (bitClk),
  .rstN        (rstN),
  .portDisable (portDisable),
  .modeSel     (modeSel),
  .serOut      (serOut),
  .serOutEn    (serOutEn),
  .rxData      (rxData),
  .rxValid     (rxValid)
);

// File: tb/tdm_slot_port_tb.sv
`timescale 1ns/1ps
module tdm_slot_port_tb;
  logic       bitClk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameSync = 1'b0;
  logic       serIn = 1'b0;
  logic [4:0] inSlot = '0;
  logic [4:0] outSlot = '0;
  logic       expandSide = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic       portDisable = 1'b0;
  logic [7:0] txData = '0;
  logic       serOut;
  logic       serOutEn;
  logic [7:0] rxData;
  logic       rxValid;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] expQ[$];
  logic [7:0] lastRx = '0;
  bit prevValid = 0;
  bit done = 0;

  always #2.5 bitClk = ~bitClk;

  tdm_slot_port u_dut (
    .bitClk(bitClk), .rstN(rstN), .frameSync(frameSync), .serIn(serIn),
    .inSlot(inSlot), .outSlot(outSlot), .expandSide(expandSide),
    .modeSel(modeSel), .portDisable(portDisable), .txData(txData),
    .serOut(serOut), .serOutEn(serOutEn), .rxData(rxData), .rxValid(rxValid)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  // monitor: pops expected received words
  initial begin
    forever begin
      @(posedge bitClk);
      #2;
      if (rstN && !done) begin
        if (rxValid) begin
          check(!prevValid, "R4", "strobe wider than one period", 1, 0);
          if (!prevValid) begin
            if (expQ.size() == 0) check(0, "R4", "unexpected strobe", 1, 0);
            else begin
              logic [7:0] e;
              e = expQ.pop_front();
              check(rxData == e, "R3", "received word", rxData, e);
            end
          end
        end
        prevValid = rxValid;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge bitClk);
    check(0, "R1", "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  task automatic leadSync();
    @(posedge bitClk); #1;
    frameSync = 1'b1;
  endtask

  // one frame of 256 bit periods; sync for the next frame in the last one
  task automatic runFrame(input int inS, input int outS, input bit ex,
                          input logic [1:0] md, input bit dis,
                          input logic [7:0] inWord, input logic [7:0] txW,
                          input logic [7:0] txW2);
    int inW, outW;
    logic [7:0] snapM;
    string enReq;
    inSlot = 5'(inS); outSlot = 5'(outS); expandSide = ex;
    modeSel = md; portDisable = dis; txData = txW;
    inW  = (md == 2'b01 || !ex) ? 8 : 4;
    outW = (md == 2'b01 || ex)  ? 8 : 4;
    enReq = dis ? "R9" : (md[1] ? "R8" : "R5");
    snapM = '0;
    for (int p = 0; p < 256; p++) begin
      int slot, b;
      bit expEn;
      slot = p / 8; b = p % 8;
      @(posedge bitClk); #1;
      if (slot == outS && b == 0) snapM = (md == 2'b01) ? lastRx : txW;
      expEn = !dis && !md[1] && slot == outS && b < outW;
      check(serOutEn == expEn, enReq, "drive enable", serOutEn, expEn);
      if (expEn)
        check(serOut == snapM[outW-1-b], (md == 2'b01) ? "R7" : "R6",
              "serial out bit", serOut, snapM[outW-1-b]);
      else
        check(serOut == 1'b0, "R5", "undriven line level", serOut, 0);
      if (slot == outS && b == 1) txData = txW2;
      frameSync = (p == 255);
      if (slot == inS && b < inW) serIn = inWord[inW-1-b];
      else                        serIn = p[0] ^ p[3];
      if (slot == inS && b == inW - 1) begin
        logic [7:0] w;
        w = (inW == 8) ? inWord : {4'b0, inWord[3:0]};
        expQ.push_back(w);
        lastRx = w;
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge bitClk);
    #1;
    check(serOutEn == 1'b0, "R1", "reset enable", serOutEn, 0);
    check(serOut == 1'b0, "R1", "reset serOut", serOut, 0);
    check(rxValid == 1'b0, "R1", "reset strobe", rxValid, 0);
    check(rxData == 8'h00, "R1", "reset word", rxData, 0);
    rstN = 1'b1;
    // no sync yet: slot 0 configured, nothing may happen
    for (int i = 0; i < 24; i++) begin
      @(posedge bitClk); #1;
      serIn = i[0];
      check(serOutEn == 1'b0, "R1", "drive before sync", serOutEn, 0);
      check(rxValid == 1'b0, "R1", "strobe before sync", rxValid, 0);
    end
    leadSync();
    runFrame(3, 5, 0, 2'b00, 0, 8'hA5, 8'h3C, 8'hFF);   // compress side
    runFrame(10, 2, 1, 2'b00, 0, 8'h09, 8'h96, 8'h00);  // expand side
    runFrame(0, 0, 0, 2'b00, 0, 8'h81, 8'h7E, 8'h00);   // R2 slot 0
    runFrame(31, 31, 1, 2'b00, 0, 8'h06, 8'h0B, 8'hF0); // R2 last slot
    runFrame(4, 7, 1, 2'b01, 0, 8'h5A, 8'h00, 8'h11);   // R7 loop, rx first
    runFrame(20, 6, 0, 2'b01, 0, 8'hC3, 8'h00, 8'h22);  // R7 loop, tx first
    runFrame(12, 12, 0, 2'b10, 0, 8'h77, 8'h55, 8'h00); // R8 idle
    runFrame(9, 14, 1, 2'b11, 0, 8'h0D, 8'h55, 8'h00);  // R8 idle alt code
    runFrame(9, 14, 1, 2'b00, 1, 8'h0E, 8'hAA, 8'h00);  // R9 disable
    runFrame(1, 30, 1, 2'b00, 0, 8'h03, 8'hE1, 8'h1E);  // back to normal
    frameSync = 1'b0;
    repeat (4) @(posedge bitClk);
    #3;
    check(expQ.size() == 0, "R4", "words left unreceived", expQ.size(), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule